// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

Two 8-bit timer channels share one register bus. Each channel has a counter, two compare registers (A and B), a control register, an output-action register, three status flags and one waveform output. A channel counts ticks from a source picked by its clock-select field. The sources are three prescaler strobes, the rising edge of its external clock pin, or nothing. Compare matches can clear the counter, set flags, raise interrupt requests and drive the waveform output high, drive it low or toggle it.

Clock-select code 3'b100 chains the two channels. If channel 0 carries that code, the pair becomes one 16-bit counter. Channel 0 is the high byte and channel 1 the low byte, and the low byte counts the source selected by channel 1. Channel 0 then reacts to full 16-bit matches, channel 1 reacts to low-byte matches only, and only channel 0's clear setting applies to the pair. If channel 1 carries the code, channel 1 counts the compare-A match events of channel 0, and each channel keeps its own rules. If both channels carry the code, the setting is invalid and both counters hold.

Top module: `tmr_pair`

## Requirements
- R1: Register map: `bus_addr[3]` picks the channel and `bus_addr[2:0]` picks the register: 0 control, 1 output action, 2 status, 3 counter, 4 compare A, 5 compare B. Codes 6 and 7 read as zero. All registers are zero after reset, and reads are combinational on `bus_rdata`. Control bits are [2:0] clock select, [4:3] clear select, [5] compare-A interrupt enable, [6] compare-B interrupt enable, [7] overflow interrupt enable. Output-action bits are [1:0] for A and [3:2] for B. Status bits are [0] match A, [1] match B, [2] overflow.
- R2: Clock select: 000, 110 and 111 stop the counter. 001, 010 and 011 count cycles in which `pre_tick[0]`, `pre_tick[1]` or `pre_tick[2]` is high. 101 counts rising edges of the channel's `ext_clk` bit.
- R3: A match event happens on a tick taken while the counter equals a compare register. Clear select 00 never clears. 01 clears on an A event, 10 clears on a B event, and 11 clears on a rising edge of the channel's `ext_rst` bit. A cleared counter goes to 0 instead of incrementing.
- R4: Output action 00 keeps the output, 01 drives it low, 10 drives it high and 11 toggles it. When A and B events coincide, only the A action applies.
- R5: A flag sets on its event. Writing 0 to a status bit clears the flag only if that bit read as 1 in an earlier status read. A hardware set in the same cycle as a clear leaves the flag set.
- R6: `irq_a`, `irq_b` and `irq_ov` for a channel are high while the matching flag and its enable bit are both set.
- R7: In 8-bit use, an increment from 0xFF to 0x00 sets the overflow flag. A clear does not set it.
- R8: With channel 0 selecting 100, the pair counts as a 16-bit value {channel 0, channel 1}. The low byte ticks on channel 1's source, and the high byte increments when the low byte wraps.
- R9: In 16-bit mode, channel 0's flags and output react to 16-bit matches against {compare 0, compare 1}. Channel 1's flags and output react to low-byte matches.
- R10: In 16-bit mode, channel 0's clear select clears both bytes together. Channel 1's clear select and its `ext_rst` bit have no effect.
- R11: In 16-bit mode, only the wrap from 0xFFFF to 0x0000 sets an overflow flag, and that flag is channel 0's. Channel 1's overflow flag never sets.
- R12: With channel 1 selecting 100 and channel 0 not selecting it, channel 1 increments once per compare-A event of channel 0.
- R13: With both channels selecting 100, neither counter changes except by a bus write.
- R14: A bus write to a counter takes effect over any tick or clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clearing) |
| bus_addr | input | 4 | Channel and register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pre_tick | input | 3 | Prescaler strobes |
| ext_clk | input | 2 | External clock pins, one per channel |
| ext_rst | input | 2 | External counter reset pins, one per channel |
| tmo | output | 2 | Waveform outputs |
| irq_a | output | 2 | Compare-A interrupt requests |
| irq_b | output | 2 | Compare-B interrupt requests |
| irq_ov | output | 2 | Overflow interrupt requests |

## Verification
Clear-on-match runs sweep the compare value from 0 up to 254, with tick counts that are not multiples of the period. The final counter value then exposes off-by-one errors in the period, and the output parity exposes a missed or doubled event. Compare-A and compare-B sweeps are run separately, so that a swap of the two clear codes shows up. In 16-bit mode, a thousand ticks run from a start value below the byte boundary, against a bench model stepped once per tick. This separates a 16-bit match from a low-byte match and shows whether channel 1's clear setting leaks in. Single runs cover stopped and unused clock codes, external edges, the flag read-then-write protocol with a simultaneous set, the two overflow forms, match counting and the invalid double-chain setting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int PRE_N = 3;

    localparam logic [2:0] CKS_OFF   = 3'b000;
    localparam logic [2:0] CKS_CHAIN = 3'b100;
    localparam logic [2:0] CKS_EXT   = 3'b101;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_OACT = 3'd1;
    localparam logic [2:0] REG_STAT = 3'd2;
    localparam logic [2:0] REG_CNT  = 3'd3;
    localparam logic [2:0] REG_CMPA = 3'd4;
    localparam logic [2:0] REG_CMPB = 3'd5;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_CMPA = 2'b01,
        CLR_CMPB = 2'b10,
        CLR_EXT  = 2'b11
    } clr_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } out_act_e;

    typedef struct packed {
        logic inc;
        logic clr;
        logic ev_a;
        logic ev_b;
        logic ev_ov;
    } step_t;

    function automatic logic apply_act(input logic [1:0] act, input logic cur);
        case (out_act_e'(act))
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TOG:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic step_t chan_step(input logic en, input logic eq_a,
                                        input logic eq_b, input logic at_max,
                                        input logic [1:0] csel, input logic rst_edge);
        step_t s;
        s.inc  = en;
        s.ev_a = en & eq_a;
        s.ev_b = en & eq_b;
        s.clr  = ((clr_sel_e'(csel) == CLR_CMPA) & s.ev_a)
               | ((clr_sel_e'(csel) == CLR_CMPB) & s.ev_b)
               | ((clr_sel_e'(csel) == CLR_EXT)  & rst_edge);
        s.ev_ov = en & at_max & ~s.clr;
        return s;
    endfunction
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = din;
        rise   = din & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  logic [2:0]       cks,
    input  logic [PRE_N-1:0] pre_tick,
    input  logic             ext_edge,
    output logic             tick
);
    always_comb begin
        case (cks)
            3'b001:  tick = pre_tick[0];
            3'b010:  tick = pre_tick[1];
            3'b011:  tick = pre_tick[2];
            CKS_EXT: tick = ext_edge;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_reg,
    input  logic [DW-1:0] wdata,
    input  logic          rd_stat,
    input  step_t         step,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmpa,
    output logic [DW-1:0] cmpb,
    output logic [7:0]    ctrl,
    output logic [3:0]    oact,
    output logic [2:0]    flags,
    output logic          tmo,
    output logic          irq_a,
    output logic          irq_b,
    output logic          irq_ov
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] cmpa;
        logic [DW-1:0] cmpb;
        logic [7:0]    ctrl;
        logic [3:0]    oact;
        logic [2:0]    flags;
        logic [2:0]    arm;
        logic          tmo;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [2:0]  sw_clr;
    logic [2:0]  hw_set;

    always_comb begin
        st_d   = st_q;
        sw_clr = '0;
        hw_set = {step.ev_ov, step.ev_b, step.ev_a};

        if (wr_en) begin
            case (wr_reg)
                REG_CTRL: st_d.ctrl = wdata[7:0];
                REG_OACT: st_d.oact = wdata[3:0];
                REG_CMPA: st_d.cmpa = wdata;
                REG_CMPB: st_d.cmpb = wdata;
                REG_STAT: sw_clr    = st_q.arm & ~wdata[2:0];
                default:  ;
            endcase
        end

        if (wr_en && wr_reg == REG_CNT) st_d.cnt = wdata;
        else if (step.clr)              st_d.cnt = '0;
        else if (step.inc)              st_d.cnt = st_q.cnt + 1'b1;

        st_d.flags = (st_q.flags & ~sw_clr) | hw_set;
        if (rd_stat) st_d.arm = st_q.flags;
        else         st_d.arm = st_q.arm & ~sw_clr;

        if (step.ev_a)      st_d.tmo = apply_act(st_q.oact[1:0], st_q.tmo);
        else if (step.ev_b) st_d.tmo = apply_act(st_q.oact[3:2], st_q.tmo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign cmpa   = st_q.cmpa;
    assign cmpb   = st_q.cmpb;
    assign ctrl   = st_q.ctrl;
    assign oact   = st_q.oact;
    assign flags  = st_q.flags;
    assign tmo    = st_q.tmo;
    assign irq_a  = st_q.flags[0] & st_q.ctrl[5];
    assign irq_b  = st_q.flags[1] & st_q.ctrl[6];
    assign irq_ov = st_q.flags[2] & st_q.ctrl[7];
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [PRE_N-1:0] pre_tick,
    input  logic [NCH-1:0]   ext_clk,
    input  logic [NCH-1:0]   ext_rst,
    output logic [NCH-1:0]   tmo,
    output logic [NCH-1:0]   irq_a,
    output logic [NCH-1:0]   irq_b,
    output logic [NCH-1:0]   irq_ov
);
    localparam int WW = 2 * DW;

    logic [DW-1:0]  cnt_w  [NCH];
    logic [DW-1:0]  cmpa_w [NCH];
    logic [DW-1:0]  cmpb_w [NCH];
    logic [7:0]     ctrl_w [NCH];
    logic [3:0]     oact_w [NCH];
    logic [2:0]     flag_w [NCH];
    step_t          step_w [NCH];
    logic [NCH-1:0] base_tick;
    logic [NCH-1:0] clk_edge, rst_edge;

    tmr_edge_det #(.N(2 * NCH)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_rst, ext_clk}),
        .rise ({rst_edge, clk_edge})
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_tick_sel u_sel (
            .cks     (ctrl_w[i][2:0]),
            .pre_tick(pre_tick),
            .ext_edge(clk_edge[i]),
            .tick    (base_tick[i])
        );

        tmr_chan #(.DW(DW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr && (bus_addr[3] == 1'(i))),
            .wr_reg (bus_addr[2:0]),
            .wdata  (bus_wdata),
            .rd_stat(bus_rd && (bus_addr[3] == 1'(i)) && (bus_addr[2:0] == REG_STAT)),
            .step   (step_w[i]),
            .cnt    (cnt_w[i]),
            .cmpa   (cmpa_w[i]),
            .cmpb   (cmpb_w[i]),
            .ctrl   (ctrl_w[i]),
            .oact   (oact_w[i]),
            .flags  (flag_w[i]),
            .tmo    (tmo[i]),
            .irq_a  (irq_a[i]),
            .irq_b  (irq_b[i]),
            .irq_ov (irq_ov[i])
        );
    end

    // Chaining decisions: which tick, clear and events each channel sees.
    logic          mode16, mcount, bad_cfg;
    logic [WW-1:0] wide_cnt;
    step_t         wide_s;
    logic          en1;

    always_comb begin
        mode16   = (ctrl_w[0][2:0] == CKS_CHAIN) && (ctrl_w[1][2:0] != CKS_CHAIN);
        mcount   = (ctrl_w[1][2:0] == CKS_CHAIN) && (ctrl_w[0][2:0] != CKS_CHAIN);
        bad_cfg  = (ctrl_w[0][2:0] == CKS_CHAIN) && (ctrl_w[1][2:0] == CKS_CHAIN);
        wide_cnt = {cnt_w[0], cnt_w[1]};

        step_w[0] = chan_step(base_tick[0], cnt_w[0] == cmpa_w[0], cnt_w[0] == cmpb_w[0],
                              cnt_w[0] == '1, ctrl_w[0][4:3], rst_edge[0]);
        en1 = mcount ? step_w[0].ev_a : base_tick[1];
        step_w[1] = chan_step(en1, cnt_w[1] == cmpa_w[1], cnt_w[1] == cmpb_w[1],
                              cnt_w[1] == '1, ctrl_w[1][4:3], rst_edge[1]);

        wide_s = chan_step(base_tick[1], wide_cnt == {cmpa_w[0], cmpa_w[1]},
                           wide_cnt == {cmpb_w[0], cmpb_w[1]}, wide_cnt == '1,
                           ctrl_w[0][4:3], rst_edge[0]);

        if (mode16) begin
            step_w[0].inc   = base_tick[1] & (cnt_w[1] == '1);
            step_w[0].clr   = wide_s.clr;
            step_w[0].ev_a  = wide_s.ev_a;
            step_w[0].ev_b  = wide_s.ev_b;
            step_w[0].ev_ov = wide_s.ev_ov;
            step_w[1].inc   = base_tick[1];
            step_w[1].clr   = wide_s.clr;
            step_w[1].ev_a  = base_tick[1] & (cnt_w[1] == cmpa_w[1]);
            step_w[1].ev_b  = base_tick[1] & (cnt_w[1] == cmpb_w[1]);
            step_w[1].ev_ov = 1'b0;
        end
        if (bad_cfg) begin
            step_w[0] = '0;
            step_w[1] = '0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr[2:0])
            REG_CTRL: bus_rdata = DW'(ctrl_w[bus_addr[3]]);
            REG_OACT: bus_rdata = DW'(oact_w[bus_addr[3]]);
            REG_STAT: bus_rdata = DW'(flag_w[bus_addr[3]]);
            REG_CNT:  bus_rdata = cnt_w[bus_addr[3]];
            REG_CMPA: bus_rdata = cmpa_w[bus_addr[3]];
            REG_CMPB: bus_rdata = cmpb_w[bus_addr[3]];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [3:0]    bus_addr,
    input logic [1:0]    tmo,
    input logic [DW-1:0] cnt0,
    input logic [DW-1:0] cnt1,
    input logic [4:0]    ctrl0,
    input logic [4:0]    ctrl1,
    input logic [2:0]    flags0,
    input logic [2:0]    flags1
);
    logic wcnt_any, wcnt0, wstat0, mode16, both_chain;

    always_comb begin
        wcnt_any   = bus_wr && (bus_addr[2:0] == 3'd3);
        wcnt0      = bus_wr && (bus_addr == 4'h3);
        wstat0     = bus_wr && (bus_addr == 4'h2);
        mode16     = (ctrl0[2:0] == 3'b100) && (ctrl1[2:0] != 3'b100);
        both_chain = (ctrl0[2:0] == 3'b100) && (ctrl1[2:0] == 3'b100);
    end

    // R2: a stopped channel without external clearing keeps its count
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[2:0] == 3'b000 && ctrl0[4:3] != 2'b11 && !wcnt0) |=> $stable(cnt0));

    // R4: an output change comes with a match flag
    a_r4_out_needs_match0: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmo[0]) |-> (flags0[0] || flags0[1]));
    a_r4_out_needs_match1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmo[1]) |-> (flags1[0] || flags1[1]));

    // R5: a set flag stays set without a status write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags0[0] && !wstat0) |=> flags0[0]);

    // R10: in 16-bit mode the high byte only moves with a low-byte wrap or a joint clear
    a_r10_joint_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && !wcnt_any && cnt1 != '1) |=>
            ((cnt0 == $past(cnt0)) && (cnt1 == $past(cnt1) || cnt1 == DW'($past(cnt1) + 1'b1)))
            || (cnt0 == '0 && cnt1 == '0));

    // R11: channel 1 overflow never sets in 16-bit mode
    a_r11_low_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && !flags1[2]) |=> !flags1[2]);

    // R13: invalid double chaining holds both counters
    a_r13_bad_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (both_chain && !wcnt_any) |=> (cnt0 == $past(cnt0) && cnt1 == $past(cnt1)));
endmodule

bind tmr_pair tmr_pair_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .tmo     (tmo),
    .cnt0    (cnt_w[0]),
    .cnt1    (cnt_w[1]),
    .ctrl0   (ctrl_w[0][4:0]),
    .ctrl1   (ctrl_w[1][4:0]),
    .flags0  (flag_w[0]),
    .flags1  (flag_w[1])
);

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] pre_tick = '0;
    logic [1:0] ext_clk = '0, ext_rst = '0;
    logic [1:0] tmo, irq_a, irq_b, irq_ov;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_pair dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pre_tick(pre_tick), .ext_clk(ext_clk), .ext_rst(ext_rst),
        .tmo(tmo), .irq_a(irq_a), .irq_b(irq_b), .irq_ov(irq_ov)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a); bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int sel, input int n);
        if (n > 0) begin
            pre_tick[sel] = 1'b1;
            repeat (n) @(negedge clk);
            pre_tick[sel] = 1'b0;
        end
    endtask

    task automatic pulse_clk(input int ch);
        ext_clk[ch] = 1'b1; @(negedge clk);
        ext_clk[ch] = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_rst(input int ch);
        ext_rst[ch] = 1'b1; @(negedge clk);
        ext_rst[ch] = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, k, t_exp, v16, m16, m8;
        int avals[5];
        int bvals[4];
        avals = '{0, 1, 3, 9, 254};
        bvals = '{0, 2, 6, 100};

        do_reset();
        // R1: reset state of every register and output
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check("R1 reset reg", v, 0);
        end
        check("R1 reset tmo", int'(tmo), 0);
        check("R1 reset irq", int'({irq_a, irq_b, irq_ov}), 0);
        wr(4'hC, 8'h5A); rd(4'hC, v); check("R1 cmpA ch1 readback", v, 8'h5A);

        // R2: clock select codes
        do_reset();
        wr(0, 8'h02); tick(0, 5); rd(3, v); check("R2 other strobe ignored", v, 0);
        tick(1, 5); rd(3, v); check("R2 strobe 1 counts", v, 5);
        wr(0, 8'h03); tick(2, 3); rd(3, v); check("R2 strobe 2 counts", v, 8);
        wr(0, 8'h00); tick(0, 4); tick(1, 4); rd(3, v); check("R2 stopped", v, 8);
        wr(0, 8'h06); tick(0, 4); tick(2, 4); rd(3, v); check("R2 unused code", v, 8);
        wr(0, 8'h05);
        for (int i = 0; i < 6; i++) pulse_clk(0);
        pulse_clk(1);
        rd(3, v); check("R2 external edges", v, 14);

        // R3 R4 R5: clear on compare A sweep with toggle output
        do_reset();
        t_exp = 0;
        foreach (avals[i]) begin
            wr(0, 8'h09); wr(1, 8'h03); wr(4, avals[i]); wr(3, 0);
            rd(2, v); wr(2, 0);
            k = 2 * (avals[i] + 1) + avals[i] / 2 + 1;
            tick(0, k);
            t_exp ^= (k / (avals[i] + 1)) & 1;
            rd(3, v); check("R3 clear on A count", v, k % (avals[i] + 1));
            check("R4 toggle on A", int'(tmo[0]), t_exp);
            rd(2, v); check("R3 flag A set", v & 1, 1);
            check("R7 no overflow on clear", (v >> 2) & 1, 0);
        end

        // R3 R4: clear on compare B sweep
        do_reset();
        t_exp = 0;
        wr(4, 8'hFF);
        foreach (bvals[i]) begin
            wr(0, 8'h11); wr(1, 8'h0C); wr(5, bvals[i]); wr(3, 0);
            k = 3 * (bvals[i] + 1) + 1;
            tick(0, k);
            t_exp ^= (k / (bvals[i] + 1)) & 1;
            rd(3, v); check("R3 clear on B count", v, k % (bvals[i] + 1));
            check("R4 toggle on B", int'(tmo[0]), t_exp);
            rd(2, v); check("R3 flag B set", (v >> 1) & 1, 1);
        end

        // R4: drive codes and A priority
        do_reset();
        wr(0, 8'h09); wr(4, 5); wr(5, 5);
        wr(1, 8'h06); tick(0, 6); check("R4 A high wins over B low", int'(tmo[0]), 1);
        wr(1, 8'h09); tick(0, 6); check("R4 A low wins over B high", int'(tmo[0]), 0);
        wr(1, 8'h0C); tick(0, 6); check("R4 A keep blocks B toggle", int'(tmo[0]), 0);

        // R5 R6: flag protocol and interrupts
        do_reset();
        wr(0, 8'h21); wr(4, 2); tick(0, 3);
        check("R6 irq_a raised", int'(irq_a[0]), 1);
        check("R6 irq_b quiet", int'(irq_b[0]), 0);
        wr(2, 0); rd(2, v); check("R5 unarmed write keeps flag", v & 1, 1);
        wr(2, 0); rd(2, v); check("R5 armed write clears flag", v & 1, 0);
        check("R6 irq_a dropped", int'(irq_a[0]), 0);
        wr(3, 2); tick(0, 1); rd(2, v); wr(3, 2);
        bus_addr = 4'h2; bus_wdata = 8'h00; bus_wr = 1'b1; pre_tick[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pre_tick[0] = 1'b0;
        rd(2, v); check("R5 set wins over clear", v & 1, 1);

        // R7 R14: overflow and counter write priority
        do_reset();
        wr(0, 8'h81); wr(3, 8'hF0); tick(0, 20);
        rd(3, v); check("R7 wrapped count", v, 4);
        rd(2, v); check("R7 overflow flag", (v >> 2) & 1, 1);
        check("R6 irq_ov raised", int'(irq_ov[0]), 1);
        bus_addr = 4'h3; bus_wdata = 8'h40; bus_wr = 1'b1; pre_tick[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pre_tick[0] = 1'b0;
        rd(3, v); check("R14 write beats tick", v, 8'h40);

        // R8 R9 R10: 16-bit counting against a stepped model
        do_reset();
        wr(4'h8, 8'h09); wr(0, 8'h0C); wr(1, 8'h03); wr(4'h9, 8'h03);
        wr(4, 8'h02); wr(4'hC, 8'h05); wr(3, 8'h01); wr(4'hB, 8'hF0);
        v16 = 16'h01F0; m16 = 0; m8 = 0;
        for (int i = 0; i < 1000; i++) begin
            if ((v16 & 8'hFF) == 5) m8++;
            if (v16 == 16'h0205) begin m16++; v16 = 0; end
            else v16 = (v16 + 1) & 16'hFFFF;
        end
        tick(0, 1000);
        rd(3, v); check("R8 high byte", v, v16 >> 8);
        rd(4'hB, v); check("R10 low byte not split-cleared", v, v16 & 8'hFF);
        check("R9 ch0 output on 16-bit match", int'(tmo[0]), m16 & 1);
        check("R9 ch1 output on low match", int'(tmo[1]), m8 & 1);

        // R10: external reset in 16-bit mode
        wr(0, 8'h1C); wr(4'h8, 8'h19); wr(3, 8'h12); wr(4'hB, 8'h34);
        pulse_rst(1);
        rd(3, v); check("R10 ch1 reset ignored hi", v, 8'h12);
        rd(4'hB, v); check("R10 ch1 reset ignored lo", v, 8'h34);
        pulse_rst(0);
        rd(3, v); check("R10 joint clear hi", v, 0);
        rd(4'hB, v); check("R10 joint clear lo", v, 0);

        // R11: 16-bit overflow
        do_reset();
        wr(0, 8'h84); wr(4'h8, 8'h01); wr(3, 8'hFF); wr(4'hB, 8'hFE);
        tick(0, 3);
        rd(4'hB, v); check("R11 wrapped low", v, 1);
        rd(3, v); check("R11 wrapped high", v, 0);
        rd(2, v); check("R11 ch0 overflow", (v >> 2) & 1, 1);
        rd(4'hA, v); check("R11 ch1 no overflow", (v >> 2) & 1, 0);
        check("R11 irq_ov ch0", int'(irq_ov[0]), 1);

        // R12: compare-match counting
        do_reset();
        wr(0, 8'h09); wr(4, 4); wr(4'h8, 8'h04);
        tick(0, 23);
        rd(3, v); check("R12 ch0 count", v, 3);
        rd(4'hB, v); check("R12 ch1 counts A events", v, 4);

        // R13: invalid double chaining
        do_reset();
        wr(0, 8'h04); wr(4'h8, 8'h04); wr(3, 7); wr(4'hB, 9);
        tick(0, 10); tick(1, 10);
        rd(3, v); check("R13 ch0 held", v, 7);
        rd(4'hB, v); check("R13 ch1 held", v, 9);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule